// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers thirty-two level-sensitive interrupt request lines into a single interrupt output for a processor. Every line first crosses into the block's clock domain through a two-flop synchroniser. A per-line polarity bit then turns it into an active-high "asserted" condition. A sticky status register records every line seen asserted. The status is masked by a per-line enable register. A global gate then decides whether the combined result may reach the registered output pin.

Software uses a plain 32-bit register port with word offsets. Its handler reads the status word and services the sources it finds there. It clears status bits by writing ones to them, and repeats the read until the word is zero. Because the lines are level-sensitive, a bit that is cleared while its line is still asserted is set again at once. The handler's loop therefore cannot lose an interrupt. Sources are numbered from the most significant end: input `irq_in[n]` is source n and occupies bit 31−n of every per-source register.

Top module: `irq_aggregator`

## Requirements
- R1: Source n (input `irq_in[n]`) occupies register bit 31−n in the status, enable, polarity and raw-input registers, so source 0 is bit 31.
- R2: The raw-input register at offset 0x5C reads the synchronised input lines in R1 bit order; writes to it have no effect.
- R3: Polarity register at 0x58: a bit at 0 treats the line as asserted when high, a bit at 1 treats it as asserted when low.
- R4: Status register at 0x50: a bit becomes set on any clock where its polarity-corrected synchronised line is asserted, and stays set after the line deasserts.
- R5: Writing the status register clears each bit written as 1 and leaves each bit written as 0; writing 0xFFFFFFFF clears every bit whose line is not asserted.
- R6: When a clear and an assertion of the same bit fall in the same cycle, the bit stays set, so a cleared bit whose line is still asserted reads back as 1.
- R7: Enable register at 0x54: only sources whose enable bit is 1 can drive `irq_out`.
- R8: The global gate register at 0x04 must hold a nonzero value for `irq_out` to assert; a zero value suppresses it.
- R9: `irq_out` is a register output. It is high on the clock after (status AND enable) is nonzero with the gate nonzero, and low on the clock after either condition fails. A line change reaches `irq_out` on the fourth rising edge.
- R10: After reset every register reads zero and `irq_out` is low: all sources disabled and active-high.
- R11: Reads of any offset other than 0x04, 0x50, 0x54, 0x58 and 0x5C return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 32 | Asynchronous interrupt lines, bit n is source n |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 12 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case is a clear write that lands in the same cycle as a still-asserted line. Only a level held through the clear shows that setting wins over clearing. The stimulus holds lines steady across random clear masks, including all-ones masks, and also drops lines before clearing, so both outcomes occur. The bench also flips polarity bits while lines are held. A line that is low and inverted then becomes asserted with no change at the pins, which exercises the polarity path separately from the synchroniser.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants for the interrupt aggregator.
// Assumes byte offsets, word aligned, 12-bit offset space.
package irq_agg_pkg;
    localparam int unsigned REG_ADDR_W = 12;

    localparam logic [REG_ADDR_W-1:0] OFS_GATE   = 12'h004;
    localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 12'h050;
    localparam logic [REG_ADDR_W-1:0] OFS_ENABLE = 12'h054;
    localparam logic [REG_ADDR_W-1:0] OFS_POLAR  = 12'h058;
    localparam logic [REG_ADDR_W-1:0] OFS_RAW    = 12'h05C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GATE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_POLAR,
        SEL_RAW
    } reg_sel_e;

    // Decode an offset into a register select
    function automatic reg_sel_e decode_ofs(input logic [REG_ADDR_W-1:0] a);
        case (a)
            OFS_GATE:   return SEL_GATE;
            OFS_STATUS: return SEL_STATUS;
            OFS_ENABLE: return SEL_ENABLE;
            OFS_POLAR:  return SEL_POLAR;
            OFS_RAW:    return SEL_RAW;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irq_agg_sync.sv
// Module: irq_agg_sync
// Multi-stage synchroniser for a vector of asynchronous lines.
// Assumes each line is a slow level; bits are synchronised independently.
module irq_agg_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_async;
                end
            end else begin : g_next
                // Further resolution flops
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_agg_status.sv
// Module: irq_agg_status
// Polarity correction and sticky status with write-one-to-clear.
// Assumes inputs already synchronised and in register bit order.
// Setting takes priority over clearing in the same cycle.
module irq_agg_status #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_sync,
    input  logic [WIDTH-1:0] polarity,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] active,
    output logic [WIDTH-1:0] status_q
);
    // Per-bit inversion selects the asserted level
    always_comb begin
        active = line_sync ^ polarity;
    end

    // Sticky status: clear first, then set from asserted lines
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | active;
    end
endmodule

// File: rtl/irq_agg_regs.sv
// Module: irq_agg_regs
// Register port: decode, configuration storage and read mux.
// Assumes a single-cycle write strobe; reads have no side effects.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]      wdata,
    input  logic [WIDTH-1:0]      status_q,
    input  logic [WIDTH-1:0]      raw_lines,
    output logic [WIDTH-1:0]      gate_q,
    output logic [WIDTH-1:0]      enable_q,
    output logic [WIDTH-1:0]      polar_q,
    output logic [WIDTH-1:0]      clr_mask,
    output logic [WIDTH-1:0]      rdata
);
    reg_sel_e sel;

    // Offset decode shared by read and write paths
    always_comb begin
        sel = decode_ofs(addr);
    end

    // Configuration registers, written only at their own offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q   <= '0;
            enable_q <= '0;
            polar_q  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_GATE)   gate_q   <= wdata;
            if (sel == SEL_ENABLE) enable_q <= wdata;
            if (sel == SEL_POLAR)  polar_q  <= wdata;
        end
    end

    // Clear request toward the status bank
    always_comb begin
        clr_mask = (wr_en && sel == SEL_STATUS) ? wdata : '0;
    end

    // Read multiplexer; unmapped offsets read zero
    always_comb begin
        case (sel)
            SEL_GATE:   rdata = gate_q;
            SEL_STATUS: rdata = status_q;
            SEL_ENABLE: rdata = enable_q;
            SEL_POLAR:  rdata = polar_q;
            SEL_RAW:    rdata = raw_lines;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_combine.sv
// Module: irq_agg_combine
// Masks status with enables, applies the global gate, registers result.
// Assumes the gate counts as open for any nonzero value.
module irq_agg_combine #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_q,
    input  logic [WIDTH-1:0] enable_q,
    input  logic [WIDTH-1:0] gate_q,
    output logic             irq_q
);
    logic any_pending;

    // Reduction of the masked status
    always_comb begin
        any_pending = |(status_q & enable_q);
    end

    // Glitch-free registered output
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_pending && (|gate_q);
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator (top)
// Aggregates level interrupt lines into one registered output.
// Assumes irq_in[n] is source n and maps it to register bit N_SRC-1-n.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      irq_in,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]      wdata,
    output logic [N_SRC-1:0]      rdata,
    output logic                  irq_out
);
    localparam int unsigned MSB = N_SRC - 1;

    logic [N_SRC-1:0] lines_msb_first;
    logic [N_SRC-1:0] lines_sync;
    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] gate_q;
    logic [N_SRC-1:0] enable_q;
    logic [N_SRC-1:0] polar_q;
    logic [N_SRC-1:0] clr_mask;

    // Source numbering: source n lands on register bit MSB-n
    generate
        for (genvar n = 0; n < N_SRC; n++) begin : g_order
            assign lines_msb_first[MSB-n] = irq_in[n];
        end
    endgenerate

    irq_agg_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (lines_msb_first),
        .q_sync  (lines_sync)
    );

    irq_agg_status #(.WIDTH(N_SRC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (lines_sync),
        .polarity  (polar_q),
        .clr_mask  (clr_mask),
        .active    (active),
        .status_q  (status_q)
    );

    irq_agg_regs #(.WIDTH(N_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .status_q  (status_q),
        .raw_lines (lines_sync),
        .gate_q    (gate_q),
        .enable_q  (enable_q),
        .polar_q   (polar_q),
        .clr_mask  (clr_mask),
        .rdata     (rdata)
    );

    irq_agg_combine #(.WIDTH(N_SRC)) u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .enable_q (enable_q),
        .gate_q   (gate_q),
        .irq_q    (irq_out)
    );
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: irq_aggregator_chk
// Property checker bound into irq_aggregator.
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [N_SRC-1:0]      rdata,
    input logic                  irq_out,
    input logic [N_SRC-1:0]      status_q,
    input logic [N_SRC-1:0]      enable_q,
    input logic [N_SRC-1:0]      polar_q,
    input logic [N_SRC-1:0]      gate_q,
    input logic [N_SRC-1:0]      active
);
    logic pend;
    logic wr_stat;
    logic wr_pol;
    logic wr_en_reg;
    logic mapped;

    // Helper terms for the properties
    always_comb begin
        pend      = ((status_q & enable_q) != '0) && (gate_q != '0);
        wr_stat   = wr_en && (addr == OFS_STATUS);
        wr_pol    = wr_en && (addr == OFS_POLAR);
        wr_en_reg = wr_en && (addr == OFS_ENABLE);
        mapped    = (addr == OFS_GATE) || (addr == OFS_STATUS) || (addr == OFS_ENABLE)
                 || (addr == OFS_POLAR) || (addr == OFS_RAW);
    end

    AST_ACTIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(active)) == $past(active))); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q))); // R4

    AST_OUT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> irq_out); // R9

    AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq_out); // R7

    AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pol |=> $stable(polar_q)); // R3

    AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_reg |=> $stable(enable_q)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == '0)); // R11
endmodule

bind irq_aggregator irq_aggregator_chk #(.N_SRC(N_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq_out  (irq_out),
    .status_q (status_q),
    .enable_q (enable_q),
    .polar_q  (polar_q),
    .gate_q   (gate_q),
    .active   (active)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;

    // Reference state kept from the requirements
    logic [31:0] m_pol, m_en, m_gate, m_stat;

    always #4 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    // R1 bit order: source n -> bit 31-n
    function automatic logic [31:0] to_reg(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] act_now();
        return to_reg(irq_in) ^ m_pol;
    endfunction

    function automatic logic exp_irq();
        return ((m_stat & m_en) != 0) && (m_gate != 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 12'h000; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
        m_stat |= act_now();
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(12'h050, v); check({tag, " R4 status"}, v, m_stat);
        rd(12'h05C, v); check({tag, " R2 raw"}, v, to_reg(irq_in));
        rd(12'h058, v); check({tag, " R3 polarity"}, v, m_pol);
        rd(12'h054, v); check({tag, " R7 enable"}, v, m_en);
        rd(12'h004, v); check({tag, " R8 gate"}, v, m_gate);
        check({tag, " R9 irq_out"}, {31'd0, irq_out}, {31'd0, exp_irq()});
    endtask

    // Watchdog: counts as a failure and still reports
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        m_pol = '0; m_en = '0; m_gate = '0; m_stat = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        check_all("R10 reset");

        // R1: source 0 is bit 31, source 31 is bit 0
        irq_in = 32'h0000_0001; settle();
        rd(12'h05C, v); check("R1 src0 raw", v, 32'h8000_0000);
        rd(12'h050, v); check("R1 src0 status", v, 32'h8000_0000);
        irq_in = 32'h8000_0000; settle();
        rd(12'h05C, v); check("R1 src31 raw", v, 32'h0000_0001);
        irq_in = '0; settle();
        // R4: both stay sticky after lines drop
        rd(12'h050, v); check("R4 sticky", v, 32'h8000_0001);

        // R5: clear only bit 31, bit 0 untouched
        wr(12'h050, 32'h8000_0000); m_stat = (m_stat & ~32'h8000_0000) | act_now(); settle();
        rd(12'h050, v); check("R5 partial clear", v, 32'h0000_0001);
        wr(12'h050, 32'hFFFF_FFFF); m_stat = act_now(); settle();
        rd(12'h050, v); check("R5 clear all", v, 32'h0);

        // R6: clear while line held stays set
        irq_in = 32'h0000_0008; settle();
        wr(12'h050, 32'hFFFF_FFFF); m_stat = act_now();
        rd(12'h050, v); check("R6 set wins", v, 32'h1000_0000);

        // R3: inverting a low line asserts it
        irq_in = '0; settle();
        wr(12'h050, 32'hFFFF_FFFF); m_stat = act_now(); settle();
        wr(12'h058, 32'h0000_0100); m_pol = 32'h0000_0100; settle();
        rd(12'h050, v); check("R3 active-low", v, 32'h0000_0100);

        // R8: gate zero suppresses; R7 enable passes
        wr(12'h054, 32'h0000_0100); m_en = 32'h0000_0100; settle();
        check("R8 gate closed", {31'd0, irq_out}, 32'd0);
        wr(12'h004, 32'h0000_0002); m_gate = 32'h2; settle();
        check("R8 gate open", {31'd0, irq_out}, 32'd1);
        wr(12'h054, 32'h0); m_en = '0; settle();
        check("R7 masked", {31'd0, irq_out}, 32'd0);

        // R9: latency from line change to irq_out
        wr(12'h058, 32'h0); m_pol = '0; settle();
        wr(12'h050, 32'hFFFF_FFFF); m_stat = act_now(); settle();
        wr(12'h054, 32'h0400_0000); m_en = 32'h0400_0000; settle();
        @(negedge clk); irq_in = 32'h0000_0020;
        repeat (3) @(negedge clk);
        check("R9 not yet", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R9 fourth edge", {31'd0, irq_out}, 32'd1);
        settle();

        // R11 and R2: unmapped and raw writes ignored
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h05C, 32'hFFFF_FFFF);
        rd(12'h008, v); check("R11 unmapped read", v, 32'h0);
        rd(12'h0A0, v); check("R11 far unmapped read", v, 32'h0);
        check_all("R11 R2 after ignored writes");

        // Random mix over all operations
        for (int it = 0; it < 150; it++) begin
            int op = $urandom_range(0, 7);
            logic [31:0] r = $urandom;
            case (op)
                0, 1: irq_in = r & $urandom;
                2: begin wr(12'h058, r); m_pol = r; end
                3: begin wr(12'h054, r); m_en = r; end
                4: begin wr(12'h004, (r[0] ? r : 32'h0)); m_gate = (r[0] ? r : 32'h0); end
                5: begin
                    logic [31:0] c = r[1] ? 32'hFFFF_FFFF : $urandom;
                    wr(12'h050, c); m_stat = (m_stat & ~c) | act_now();
                end
                6: wr(12'h05C, r);
                default: wr({$urandom_range(0, 15), 8'h00} | 12'h00C, r);
            endcase
            settle();
            check_all("RAND R5 R6");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule